// File: doc/BRIEF.md
# Descriptor Ring Receive DMA Engine

This engine stores an incoming byte stream in memory under the control of descriptors that software places in a ring. Each descriptor is 16 bytes long. Its first word holds control and status, and its second word holds the start address of the data buffer. The engine reads the control word at the current ring pointer and keeps reading it until software sets the enable bit. It then reads the buffer address and writes each accepted byte to the next byte address, so buffers need not be aligned. When the buffer is finished, the engine writes the control word back with the byte count and the error flags, optionally raises an interrupt, and moves to the next descriptor.

There are two length modes. In packet mode the stream's end-of-packet flag closes the buffer, and the hardware writes the byte count into the length field. In framing mode software places a length in the descriptor beforehand. The engine then fills exactly that many bytes, limited to a configurable maximum, and ignores packet boundaries. The stream has no back-pressure. A byte that cannot be stored is dropped and recorded as an overrun. Control comes from four static inputs: run, interrupt enable, framing mode and ring base address.

Top module: `ringrx_dma`

## Requirements
- R1: While reset is asserted, `mem_req` and `irq` are low.
- R2: The engine reads the control word at `cfg_base + ptr`. If its enable bit (bit 0) is clear, the engine reads the same word again and does not write to memory. Once enable is set, it reads the buffer address at `cfg_base + ptr + 4`.
- R3: Each accepted byte is written by one request. Bytes go to consecutive byte addresses starting at the buffer address, which may have any alignment. The request address is word aligned, the byte replicated on all four lanes, and `mem_be` has only the lane of address bits 1:0 set.
- R4: In packet mode the byte flagged with `rx_eop` is the last byte of the buffer and is stored. The length field (bits 31:16) is written back as the number of bytes stored. Any length that software placed there is ignored.
- R5: In packet mode, once `PKT_MAX` bytes are stored, further bytes of the packet are not written and the overrun bit (bit 7) is set.
- R6: In framing mode the buffer closes after `min(len, FRAME_MAX)` stored bytes, where `len` is the length field read from the descriptor, and `rx_eop` is ignored.
- R7: A byte that arrives while the previous byte write is still waiting for `mem_ack` is dropped, and the overrun bit is set.
- R8: If `rx_crc_err` is seen with any byte of the buffer, the CRC error bit (bit 8) of the written-back word is set.
- R9: Write-back is one full-word write (`mem_be` = 4'hF) to the control word. It carries the length, CRC error and overrun bits, keeps bits 3:1 as read, and clears the enable bit and all reserved bits.
- R10: After a write-back, `irq` pulses high for one cycle when both the descriptor's interrupt bit (bit 1) and `cfg_irq_en` are set, whether or not an error occurred. Otherwise `irq` stays low.
- R11: After write-back the pointer becomes zero when the wrap bit (bit 2) is set. Otherwise it advances by 16 and returns to zero on reaching `DESC_SPACE` bytes.
- R12: Bytes that arrive while no buffer is open are discarded and cause no memory write.
- R13: A memory request keeps its address, direction, enables and data unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_run | input | 1 | Engine enable |
| cfg_irq_en | input | 1 | Global receive interrupt enable |
| cfg_frame | input | 1 | 1 = framing mode, 0 = packet mode |
| cfg_base | input | ADDR_W | Byte address of descriptor slot 0 |
| rx_valid | input | 1 | Received byte present |
| rx_byte | input | 8 | Received byte |
| rx_eop | input | 1 | Byte is the last of a packet |
| rx_crc_err | input | 1 | CRC error flagged for the packet |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word-aligned request address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| irq | output | 1 | Completion interrupt pulse |

## Verification
A ring pointer that is wrong shows up in the first descriptor read after a write-back, one or two cycles after the control word changes. A byte counter that is off shows up in the written-back length, and as a missing or extra stored byte at the buffer end. Mode or overrun state that is wrong shows up in bits 8 and 7 of the written-back word. It also shows up as a byte written in place of one that should have been dropped, visible as soon as that buffer closes. An interrupt gate that is wrong shows up as a missing or extra pulse within two cycles of write-back.

// File: rtl/ringrx_pkg.sv
package ringrx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_CTRL,
      ST_RD_ADDR,
      ST_FILL,
      ST_FLUSH,
      ST_WBACK
   } rx_state_e;

   // control word bit positions decoded by software
   localparam int B_OWN   = 0;
   localparam int B_INT   = 1;
   localparam int B_WRAP  = 2;
   localparam int B_HDR   = 3;
   localparam int B_OVR   = 7;
   localparam int B_CRC   = 8;
   localparam int B_LEN   = 16;
   localparam int LEN_W   = 16;

endpackage

// File: rtl/ringrx_ptr.sv
module ringrx_ptr #(
   parameter int DESC_SPACE  = 16384,
   parameter int DESC_STRIDE = 16,
   parameter int PTR_W       = $clog2(DESC_SPACE)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             to_zero,
   output logic [PTR_W-1:0] ptr
);

   logic [PTR_W-1:0] inc;

   if ((DESC_STRIDE & (DESC_STRIDE - 1)) != 0 || DESC_STRIDE < 8) begin : g_bad_stride
      $error("DESC_STRIDE must be a power of two of at least 8");
   end
   if (DESC_SPACE % DESC_STRIDE != 0) begin : g_bad_space
      $error("DESC_SPACE must be a multiple of DESC_STRIDE");
   end

   if ((DESC_SPACE & (DESC_SPACE - 1)) == 0) begin : g_pow2
      // the counter width itself provides the wrap
      assign inc = ptr + PTR_W'(DESC_STRIDE);
   end else begin : g_cmp
      logic [PTR_W:0] sum;
      assign sum = {1'b0, ptr} + (PTR_W+1)'(DESC_STRIDE);
      assign inc = (sum >= (PTR_W+1)'(DESC_SPACE)) ? '0 : sum[PTR_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (adv) begin
         ptr <= to_zero ? '0 : inc;
      end
   end

endmodule

// File: rtl/ringrx_bytewr.sv
module ringrx_bytewr #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [7:0]        byte_in,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              ack,
   output logic              busy,
   output logic [ADDR_W-1:0] word_addr,
   output logic [3:0]        be,
   output logic [31:0]       wdata
);

   logic              pend;
   logic [ADDR_W-1:0] a_q;
   logic [7:0]        b_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         a_q  <= '0;
         b_q  <= '0;
      end else if (push) begin
         pend <= 1'b1;
         a_q  <= addr_in;
         b_q  <= byte_in;
      end else if (ack) begin
         pend <= 1'b0;
      end
   end

   assign busy      = pend;
   assign word_addr = {a_q[ADDR_W-1:2], 2'b00};
   assign wdata     = {4{b_q}};

   for (genvar l = 0; l < 4; l++) begin : g_lane
      assign be[l] = (a_q[1:0] == 2'(l));
   end

endmodule

// File: rtl/ringrx_dma.sv
module ringrx_dma
   import ringrx_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DESC_SPACE  = 16384,
   parameter int DESC_STRIDE = 16,
   parameter int PKT_MAX     = 65535,
   parameter int FRAME_MAX   = 2048
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_run,
   input  logic              cfg_irq_en,
   input  logic              cfg_frame,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              rx_eop,
   input  logic              rx_crc_err,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [3:0]        mem_be,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic              irq
);

   localparam int PTR_W = $clog2(DESC_SPACE);
   localparam logic [LEN_W-1:0] PKT_LIM   = LEN_W'(PKT_MAX);
   localparam logic [LEN_W-1:0] FRAME_LIM = LEN_W'(FRAME_MAX);

   if (PKT_MAX < 1 || PKT_MAX > 65535) begin : g_bad_pkt
      $error("PKT_MAX must fit the 16-bit length field");
   end
   if (FRAME_MAX < 1 || FRAME_MAX > PKT_MAX) begin : g_bad_frame
      $error("FRAME_MAX must lie between 1 and PKT_MAX");
   end
   if (ADDR_W > 32 || ADDR_W < PTR_W + 1) begin : g_bad_addr
      $error("ADDR_W out of range");
   end

   rx_state_e         state;
   logic [LEN_W-1:0]  len_q, target, cnt;
   logic              int_q, wrap_q, hdr_q, frame_q, ovr_q, crc_q;
   logic [ADDR_W-1:0] dptr;
   logic [PTR_W-1:0]  ptr;
   logic [ADDR_W-1:0] desc_addr;
   logic [LEN_W-1:0]  clamp;
   logic              wr_busy, wr_ack, wr_free, full, take, drop, close, adv;
   logic [ADDR_W-1:0] wr_addr;
   logic [3:0]        wr_be;
   logic [31:0]       wr_data, wb_word;

   assign desc_addr = cfg_base + ADDR_W'(ptr);
   assign clamp     = (len_q > FRAME_LIM) ? FRAME_LIM : len_q;

   // byte acceptance while a buffer is open
   assign wr_ack  = mem_ack && (state == ST_FILL || state == ST_FLUSH);
   assign wr_free = !wr_busy || wr_ack;
   assign full    = !frame_q && (cnt == PKT_LIM);
   assign take    = (state == ST_FILL) && rx_valid && wr_free && !full;
   assign drop    = (state == ST_FILL) && rx_valid && !take;
   assign close   = (state == ST_FILL) &&
                    (frame_q ? (take && (cnt + LEN_W'(1) == target))
                             : (rx_valid && rx_eop));
   assign adv     = (state == ST_WBACK) && mem_ack;

   assign wb_word = {cnt, 7'b0, crc_q, ovr_q, 3'b0, hdr_q, wrap_q, int_q, 1'b0};

   ringrx_ptr #(
      .DESC_SPACE (DESC_SPACE),
      .DESC_STRIDE(DESC_STRIDE),
      .PTR_W      (PTR_W)
   ) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (adv),
      .to_zero(wrap_q),
      .ptr    (ptr)
   );

   ringrx_bytewr #(.ADDR_W(ADDR_W)) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (take),
      .byte_in  (rx_byte),
      .addr_in  (dptr),
      .ack      (wr_ack),
      .busy     (wr_busy),
      .word_addr(wr_addr),
      .be       (wr_be),
      .wdata    (wr_data)
   );

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = desc_addr;
      mem_be    = 4'h0;
      mem_wdata = '0;
      unique case (state)
         ST_RD_CTRL: mem_req = 1'b1;
         ST_RD_ADDR: begin
            mem_req  = 1'b1;
            mem_addr = desc_addr + ADDR_W'(4);
         end
         ST_FILL, ST_FLUSH: begin
            mem_req   = wr_busy;
            mem_we    = 1'b1;
            mem_addr  = wr_addr;
            mem_be    = wr_be;
            mem_wdata = wr_data;
         end
         ST_WBACK: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_be    = 4'hF;
            mem_wdata = wb_word;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         len_q   <= '0;
         target  <= '0;
         cnt     <= '0;
         int_q   <= 1'b0;
         wrap_q  <= 1'b0;
         hdr_q   <= 1'b0;
         frame_q <= 1'b0;
         ovr_q   <= 1'b0;
         crc_q   <= 1'b0;
         dptr    <= '0;
         irq     <= 1'b0;
      end else begin
         irq <= 1'b0;
         unique case (state)
            ST_IDLE: if (cfg_run) state <= ST_RD_CTRL;
            ST_RD_CTRL: if (mem_ack) begin
               if (!cfg_run) begin
                  state <= ST_IDLE;
               end else if (mem_rdata[B_OWN]) begin
                  len_q  <= mem_rdata[B_LEN +: LEN_W];
                  int_q  <= mem_rdata[B_INT];
                  wrap_q <= mem_rdata[B_WRAP];
                  hdr_q  <= mem_rdata[B_HDR];
                  state  <= ST_RD_ADDR;
               end
            end
            ST_RD_ADDR: if (mem_ack) begin
               dptr    <= mem_rdata[ADDR_W-1:0];
               cnt     <= '0;
               ovr_q   <= 1'b0;
               crc_q   <= 1'b0;
               frame_q <= cfg_frame;
               target  <= clamp;
               state   <= (cfg_frame && clamp == '0) ? ST_FLUSH : ST_FILL;
            end
            ST_FILL: begin
               if (take) begin
                  dptr <= dptr + ADDR_W'(1);
                  cnt  <= cnt + LEN_W'(1);
               end
               if (drop) ovr_q <= 1'b1;
               if (rx_valid && rx_crc_err) crc_q <= 1'b1;
               if (close) state <= ST_FLUSH;
            end
            ST_FLUSH: if (wr_free) state <= ST_WBACK;
            ST_WBACK: if (mem_ack) begin
               irq   <= int_q && cfg_irq_en;
               state <= cfg_run ? ST_RD_CTRL : ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ringrx_dma_chk.sv
module ringrx_dma_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_irq_en,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [3:0]        mem_be,
   input logic [31:0]       mem_wdata,
   input logic              mem_ack,
   input logic              irq
);

   // R13
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_be) && $stable(mem_wdata));

   // R3
   lane_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_be != 4'hF |-> $countones(mem_be) == 1);

   // R9
   wb_en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_be == 4'hF |-> !mem_wdata[0]);

   // R10
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(cfg_irq_en));

   // R10
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

endmodule

bind ringrx_dma ringrx_dma_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/ringrx_dma_tb.sv
module ringrx_dma_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NDESC = 8;

   typedef struct packed {
      logic        frame;
      logic        irqen;
      logic        ie;
      logic        hdr;
      logic        crc;
      logic [15:0] sw_len;
      logic [7:0]  nb;
      logic [7:0]  eop_at;
      logic [7:0]  off;
      logic [15:0] exp_len;
      logic        exp_ov;
      logic        exp_irq;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h1234, 8'd5,  8'd4,   8'd0, 16'd5,  1'b0, 1'b1},
      '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'd0,    8'd6,  8'd5,   8'd3, 16'd6,  1'b0, 1'b1},
      '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'd4,    8'd4,  8'd1,   8'd1, 16'd4,  1'b0, 1'b1},
      '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'd0,    8'd3,  8'd2,   8'd2, 16'd3,  1'b0, 1'b0},
      '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'd3,    8'd3,  8'd255, 8'd0, 16'd3,  1'b0, 1'b0},
      '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'd0,    8'd50, 8'd49,  8'd0, 16'd48, 1'b1, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_run = 1'b1, cfg_irq_en = 1'b1, cfg_frame = 1'b0;
   logic [31:0] cfg_base = 32'h0;
   logic        rx_valid = 1'b0, rx_eop = 1'b0, rx_crc_err = 1'b0;
   logic [7:0]  rx_byte = 8'h00;
   logic        mem_req, mem_we, mem_ack, irq;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [3:0]  mem_be;

   logic [31:0] mem [1024] = '{default: 32'h0};
   logic        stall = 1'b0;
   logic        h_we = 1'b0;
   logic [9:0]  h_idx = '0;
   logic [31:0] h_data = '0;
   logic [31:0] last_rd = 32'hFFFF_FFFF;
   int          irq_cnt = 0, wr_cnt = 0;
   int          checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ringrx_dma #(
      .ADDR_W(32), .DESC_SPACE(NDESC*16), .DESC_STRIDE(16),
      .PKT_MAX(48), .FRAME_MAX(32)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_irq_en(cfg_irq_en),
      .cfg_frame(cfg_frame), .cfg_base(cfg_base), .rx_valid(rx_valid),
      .rx_byte(rx_byte), .rx_eop(rx_eop), .rx_crc_err(rx_crc_err),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq)
   );

   assign mem_ack   = mem_req && !stall;
   assign mem_rdata = mem[mem_addr[11:2]];

   always @(posedge clk) begin
      if (h_we) mem[h_idx] <= h_data;
      if (mem_req && mem_we && mem_ack) begin
         for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
         wr_cnt <= wr_cnt + 1;
      end
      if (mem_req && !mem_we && mem_ack && mem_addr[3:0] == 4'h0) last_rd <= mem_addr;
      if (irq) irq_cnt <= irq_cnt + 1;
   end

   function automatic logic [7:0] rdbyte(input logic [31:0] a);
      return mem[a[11:2]][{a[1:0], 3'b000} +: 8];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic host_wr(input int idx, input logic [31:0] d);
      @(negedge clk);
      h_we = 1'b1; h_idx = 10'(idx); h_data = d;
      @(negedge clk);
      h_we = 1'b0;
   endtask

   task automatic send(input int n, input logic [7:0] seed, input int eop_at, input logic crc);
      for (int j = 0; j < n; j++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_byte = seed + 8'(j);
         rx_eop = (j == eop_at); rx_crc_err = crc && (j == n - 1);
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_eop = 1'b0; rx_crc_err = 1'b0;
   endtask

   task automatic wait_done(input int idx, input string req);
      int t = 0;
      while (mem[idx][0] && t < 400) begin
         @(negedge clk);
         t++;
      end
      check(req, 32'(mem[idx][0]), 32'h0);
      repeat (4) @(negedge clk);
   endtask

   task automatic gap(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin : main
      int irq0, mism, w0;
      logic [31:0] dbase, expw;
      logic [7:0] seed;

      // R1: reset holds the outputs quiet even with the engine enabled
      gap(5);
      check("R1 mem_req in reset", 32'(mem_req), 32'h0);
      check("R1 irq in reset", 32'(irq), 32'h0);
      rst_n = 1'b1;
      gap(6);
      // R2: slot 0 disabled, engine polls it and writes nothing
      check("R2 poll slot 0", last_rd, 32'h0);
      check("R2 no write while disabled", 32'(wr_cnt), 32'h0);

      for (int i = 0; i < 6; i++) begin
         vec_t v;
         v = VECS[i];
         dbase = 32'h400 + 32'(i) * 32'h100 + 32'(v.off);
         seed = 8'h10 + 8'(i) * 8'h20;
         cfg_frame = v.frame;
         cfg_irq_en = v.irqen;
         host_wr(i*4 + 1, dbase);
         host_wr(i*4, {v.sw_len, 12'h0, v.hdr, 1'b0, v.ie, 1'b1});
         gap(4);
         irq0 = irq_cnt;
         send(int'(v.nb), seed, int'(v.eop_at), v.crc);
         wait_done(i*4, "R4 R6 completion");
         expw = {v.exp_len, 7'b0, v.crc, v.exp_ov, 3'b0, v.hdr, 1'b0, v.ie, 1'b0};
         // R9 with R4 R5 R6 R8 content
         check("R9 write-back word", mem[i*4], expw);
         mism = 0;
         for (int j = 0; j < int'(v.exp_len); j++)
            if (rdbyte(dbase + 32'(j)) !== seed + 8'(j)) mism++;
         check("R3 stored bytes", 32'(mism), 32'h0);
         check("R5 R6 nothing past end", 32'(rdbyte(dbase + 32'(v.exp_len))), 32'h0);
         check("R10 irq count", 32'(irq_cnt - irq0), 32'(v.exp_irq));
         check("R11 advance by 16", last_rd, 32'((i + 1) * 16));
      end

      // R7: overrun while a write is still pending
      cfg_frame = 1'b0; cfg_irq_en = 1'b1;
      host_wr(6*4 + 1, 32'hA00);
      host_wr(6*4, 32'h0000_0003);
      gap(4);
      irq0 = irq_cnt;
      @(negedge clk); stall = 1'b1; rx_valid = 1'b1; rx_byte = 8'h61;
      @(negedge clk); rx_byte = 8'h62;
      @(negedge clk); rx_valid = 1'b0; stall = 1'b0;
      gap(2);
      @(negedge clk); rx_valid = 1'b1; rx_byte = 8'h63; rx_eop = 1'b1;
      @(negedge clk); rx_valid = 1'b0; rx_eop = 1'b0;
      wait_done(6*4, "R7 completion");
      check("R7 overrun word", mem[6*4], 32'h0002_0082);
      check("R7 first byte kept", 32'(rdbyte(32'hA00)), 32'h61);
      check("R7 dropped byte absent", 32'(rdbyte(32'hA01)), 32'h63);
      check("R10 irq on error", 32'(irq_cnt - irq0), 32'h1);

      // R6: framing length clamped to FRAME_MAX, then R11 forced wrap
      cfg_frame = 1'b1;
      host_wr(7*4 + 1, 32'hB00);
      host_wr(7*4, {16'd100, 16'h0001});
      gap(4);
      send(32, 8'h80, 255, 1'b0);
      wait_done(7*4, "R6 clamp completion");
      check("R6 clamped length", mem[7*4], 32'h0020_0000);
      check("R11 wrap at ring end", last_rd, 32'h0);

      // R12: bytes while slot 0 is disabled are discarded
      w0 = wr_cnt;
      send(3, 8'hC0, 2, 1'b0);
      gap(10);
      check("R12 no writes", 32'(wr_cnt - w0), 32'h0);
      check("R12 byte after frame", 32'(rdbyte(32'hB20)), 32'h0);
      check("R2 slot 0 untouched", mem[0], 32'h0005_0002);
      check("R2 still polling slot 0", last_rd, 32'h0);

      // R11: wrap bit returns the pointer to slot 0
      cfg_frame = 1'b0;
      host_wr(1, 32'h480);
      host_wr(0, 32'h0000_0007);
      gap(4);
      send(2, 8'h90, 1, 1'b0);
      wait_done(0, "R11 wrap-bit completion");
      check("R9 wrap bit kept", mem[0], 32'h0002_0006);
      check("R11 wrap bit to zero", last_rd, 32'h0);
      check("R3 aligned store", 32'(rdbyte(32'h481)), 32'h91);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule